// File: doc/BRIEF.md
# Direct-Page Bit Test/Branch and Bit-Set Execution Unit

This unit runs one direct-page bit instruction for an 8-bit accumulator CPU. It is handed a program counter and the current carry flag. It then fetches the opcode byte, the direct-page address byte and, for branches, a signed relative offset over a synchronous byte-wide memory port. It reads the addressed operand byte and either tests one bit and resolves a conditional branch, or sets one bit and writes the byte back. At the end it returns the next program counter and the carry flag.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is accepted in the cycle where `cmd_valid` and `cmd_ready` are both high, and `pc_in` and `carry_in` are sampled in that cycle. `cmd_ready` then stays low until the final cycle of the instruction has passed, which holds the next command off. A caller that keeps `cmd_valid` high gets its next command accepted in the cycle right after `done`. The memory port has no back-pressure. Read data for a read issued in one cycle appears on `mem_rdata` in the next cycle. A write takes effect at the clock edge that ends the cycle in which `mem_wr` is high. Only opcodes 0x00 to 0x1F are presented to the unit, and opcode bits 7:5 are ignored.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, and `mem_rd` and `mem_wr` are both 0 until a command is accepted.
- R2: `cmd_ready` is 0 from the cycle after acceptance through the cycle in which `done` is high. It is 1 again in the following cycle.
- R3: Bytes are read in this order: the opcode at PC, the direct-page address at PC+1, the offset at PC+2 (branches only), and then the operand at {0x00, address byte}. Set-bit writes back to that same operand address.
- R4: Opcode bit 4 = 0 selects a bit-branch and bit 4 = 1 selects set-bit. Bits 3:1 give the bit index n. For a branch, bit 0 = 0 means branch if bit n is 1, and bit 0 = 1 means branch if bit n is 0.
- R5: A taken branch returns PC + 3 + sign-extended offset, taken modulo 2^16.
- R6: A branch that is not taken returns PC + 3.
- R7: For both branch senses, `carry_out` equals the value of the tested bit.
- R8: `done` is a single-cycle pulse. For a branch it is high in the 5th cycle and for set-bit in the 4th cycle, counting the acceptance cycle as cycle 1.
- R9: Set-bit writes the operand byte with bit n forced to 1 and all other bits unchanged, in its final cycle. It returns PC + 2 and passes `carry_in` through unchanged as `carry_out`.
- R10: A bit-branch never drives `mem_wr`, so the operand byte is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit is idle and accepts a command |
| pc_in | input | ADDR_W | Address of the opcode byte |
| carry_in | input | 1 | Carry flag before the instruction |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read strobe |
| done | output | 1 | Final-cycle pulse; `pc_out` and `carry_out` are valid while it is high |
| pc_out | output | ADDR_W | Next program counter |
| carry_out | output | 1 | Carry flag after the instruction |

## Verification
Taking the acceptance cycle as cycle 1, a branch's `done`, `pc_out` and `carry_out` are due in cycle 5, and set-bit results are due in cycle 4. The set-bit write lands at the edge that closes that cycle. The bench drives a command at a falling edge and samples at each later falling edge. It requires `done` to be low and `cmd_ready` to be low in every sampled cycle before the due cycle, and `done` to be high in the due cycle. In the cycle after that, it checks that `cmd_ready` has returned, counts the writes the memory model saw, and compares the operand byte with the value computed by the bench.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_OPND,
    ST_LAST
  } state_t;

  typedef struct packed {
    logic             set_op;
    logic             want_one;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [4:0] op_low,
  output dec_t       dec
);
  always_comb begin
    dec.set_op   = op_low[4];
    dec.want_one = ~op_low[0];
    dec.idx      = op_low[3:1];
  end
endmodule

// File: rtl/bitop_bitsel.sv
module bitop_bitsel
  import bitop_pkg::*;
(
  input  logic [DATA_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  idx,
  output logic              bit_val,
  output logic [DATA_W-1:0] set_byte
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx == IDX_W'(g));
  end

  assign bit_val  = |(byte_in & mask);
  assign set_byte = byte_in | mask;
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [7:0]        rel,
  input  logic              set_op,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int EXT_W = ADDR_W - 8;
  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] seq_pc;

  assign rel_ext = {{EXT_W{rel[7]}}, rel};
  assign seq_pc  = base_pc + (set_op ? ADDR_W'(2) : ADDR_W'(3));

  always_comb begin
    if (!set_op && taken) next_pc = seq_pc + rel_ext;
    else                  next_pc = seq_pc;
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              carry_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic              carry_out
);
  localparam int HI_W = ADDR_W - 8;

  state_t            state, state_nx;
  logic [ADDR_W-1:0] pc_q;
  logic              c_q;
  dec_t              dec_q, dec_now;
  logic [7:0]        dp_q, off_q;
  logic              bit_val, taken;
  logic [7:0]        set_byte;

  bitop_decode u_dec (.op_low(mem_rdata[4:0]), .dec(dec_now));

  bitop_bitsel u_sel (
    .byte_in(mem_rdata), .idx(dec_q.idx),
    .bit_val(bit_val), .set_byte(set_byte)
  );

  assign taken = (bit_val == dec_q.want_one);

  bitop_target #(.ADDR_W(ADDR_W)) u_tgt (
    .base_pc(pc_q), .rel(off_q), .set_op(dec_q.set_op),
    .taken(taken), .next_pc(pc_out)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign carry_out = dec_q.set_op ? c_q : bit_val;

  always_comb begin
    state_nx  = state;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        mem_rd   = 1'b1;
        mem_addr = pc_in;
        state_nx = ST_ADDR;
      end
      ST_ADDR: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(1);
        state_nx = dec_now.set_op ? ST_OPND : ST_OFFS;
      end
      ST_OFFS: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(2);
        state_nx = ST_OPND;
      end
      ST_OPND: begin
        mem_rd   = 1'b1;
        mem_addr = {{HI_W{1'b0}}, (dec_q.set_op ? mem_rdata : dp_q)};
        state_nx = ST_LAST;
      end
      ST_LAST: begin
        done      = 1'b1;
        mem_wr    = dec_q.set_op;
        mem_addr  = dec_q.set_op ? {{HI_W{1'b0}}, dp_q} : '0;
        mem_wdata = dec_q.set_op ? set_byte : '0;
        state_nx  = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc_q  <= '0;
      c_q   <= 1'b0;
      dec_q <= '0;
      dp_q  <= '0;
      off_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && cmd_valid) begin
        pc_q <= pc_in;
        c_q  <= carry_in;
      end
      if (state == ST_ADDR) dec_q <= dec_now;
      if (state == ST_OFFS) dp_q  <= mem_rdata;
      if (state == ST_OPND) begin
        if (dec_q.set_op) dp_q  <= mem_rdata;
        else              off_q <= mem_rdata;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10
  AST_WR_DIRECT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[ADDR_W-1:8] == '0)); // R3
  AST_WR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((mem_wdata & mem_rdata) == mem_rdata)); // R9
  AST_SET_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dec_q.set_op) |-> (pc_out == pc_q + ADDR_W'(2))); // R9
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dec_q.set_op) |-> !mem_wr); // R10
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] pc_in = '0;
  logic        carry_in = 1'b0;
  logic        mem_rd, mem_wr, done, carry_out;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0]  dp [256];
  logic [15:0] cur_pc = 16'h0100;
  logic [7:0]  pb0 = '0, pb1 = '0, pb2 = '0;
  int          wr_cnt = 0;
  logic [15:0] wr_addr = '0;

  always #4 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .pc_in(pc_in), .carry_in(carry_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .pc_out(pc_out), .carry_out(carry_out)
  );

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    if (a == cur_pc)                return pb0;
    if (a == cur_pc + 16'd1)        return pb1;
    if (a == cur_pc + 16'd2)        return pb2;
    if (a[15:8] == 8'h00)           return dp[a[7:0]];
    return 8'hEE;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= model_rd(mem_addr);
    if (mem_wr) begin
      dp[mem_addr[7:0]] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= mem_addr;
    end
  end

  function automatic logic exp_bit(input logic [7:0] op, input logic [7:0] b);
    return b[op[3:1]];
  endfunction

  function automatic logic [15:0] exp_pc(input logic [7:0] op, input logic [15:0] pc,
                                         input logic [7:0] off, input logic [7:0] b);
    logic t;
    if (op[4]) return pc + 16'd2;
    t = (exp_bit(op, b) == ~op[0]);
    return t ? pc + 16'd3 + {{8{off[7]}}, off} : pc + 16'd3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] off,
                        input logic [7:0] dpa, input logic [7:0] val, input logic cin);
    int lat;
    bit early;
    logic [15:0] got_pc;
    logic        got_c;
    logic [7:0]  exp_b;
    dp[dpa] = val;
    cur_pc = pc; pb0 = op; pb1 = dpa; pb2 = off;
    lat = op[4] ? 4 : 5;
    early = 0;
    @(negedge clk);
    wr_cnt = 0;
    cmd_valid = 1'b1; pc_in = pc; carry_in = cin;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 2; k <= lat; k++) begin
      if (k > 2) @(negedge clk);
      if (k < lat && (done || cmd_ready)) early = 1;
    end
    // R8: done due in cycle 5 (branch) or 4 (set); R2: ready low while busy
    check(!early, "R2/busy", {31'd0, early}, 32'd0);
    check(done === 1'b1, "R8", {31'd0, done}, 32'd1);
    got_pc = pc_out; got_c = carry_out;
    // R4 decode chooses sense and bit; R5/R6/R9 target
    check(got_pc === exp_pc(op, pc, off, val), op[4] ? "R9 pc" : "R4 R5 R6 pc",
          {16'd0, got_pc}, {16'd0, exp_pc(op, pc, off, val)});
    check(got_c === (op[4] ? cin : exp_bit(op, val)), op[4] ? "R9 carry" : "R7",
          {31'd0, got_c}, {31'd0, (op[4] ? cin : exp_bit(op, val))});
    @(negedge clk);
    check(cmd_ready === 1'b1 && done === 1'b0, "R2 ready back", {30'd0, cmd_ready, done}, 32'd2);
    exp_b = op[4] ? (val | (8'd1 << op[3:1])) : val;
    check(dp[dpa] === exp_b, op[4] ? "R9 data" : "R10 data", {24'd0, dp[dpa]}, {24'd0, exp_b});
    check(wr_cnt == (op[4] ? 1 : 0), op[4] ? "R9 writes" : "R10 writes", wr_cnt, op[4] ? 1 : 0);
    if (op[4]) check(wr_addr === {8'h00, dpa}, "R3 wr addr", {16'd0, wr_addr}, {24'd0, dpa});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] op;
    for (int i = 0; i < 256; i++) dp[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd_ready === 1'b1 && done === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
          "R1", {28'd0, cmd_ready, done, mem_rd, mem_wr}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1 && mem_rd === 1'b0 && mem_wr === 1'b0, "R1 idle",
          {29'd0, cmd_ready, mem_rd, mem_wr}, 32'h4);
    // directed corners
    run_op(8'h0E, 16'h0200, 8'h80, 8'h10, 8'h80, 1'b0); // R5 bit7 set, -128
    run_op(8'h01, 16'h0300, 8'h7F, 8'h11, 8'hFE, 1'b1); // R5 bit0 clear, +127
    run_op(8'h01, 16'h0300, 8'h7F, 8'h11, 8'h01, 1'b0); // R6 not taken
    run_op(8'h00, 16'hFFF0, 8'h7F, 8'h12, 8'h01, 1'b0); // R5 wrap
    run_op(8'h1E, 16'h0400, 8'h00, 8'hFF, 8'h00, 1'b1); // R9 bit7
    run_op(8'h10, 16'h0500, 8'h00, 8'h00, 8'h01, 1'b0); // R9 already set
    for (int i = 0; i < 300; i++) begin
      op = 8'($urandom % 32);
      if (op[4]) op[0] = 1'b0;
      run_op(op, 16'h0100 + 16'($urandom % 16'hFE00), 8'($urandom),
             8'($urandom), 8'($urandom), 1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule